// File: doc/BRIEF.md
# 16-bit Pair-Register ALU with Flag Update

This block holds a 16-bit pair register and an 8-bit flag byte. It applies one of seven 16-bit operations to them: add, add with carry, subtract, subtract with borrow, and the bitwise AND, XOR and OR. The pair register is always the first operand. The second operand either comes from an input word or is fetched as two byte reads from a synchronous byte memory. The low byte is read first at the given address and the high byte at the next address. The result goes back into the pair register and the flag byte is updated in the same clock edge.

A one-cycle `start` pulse launches an operation while the block is idle. The block then reads memory if needed, computes, writes back and raises `done` for one cycle. While idle, the pair register and the flag byte can be loaded directly, which sets the starting values and the incoming carry.

The carry rules are deliberately asymmetric. Add-with-carry adds the incoming carry to the operand first and truncates that sum to 16 bits before the main add. Subtract-with-borrow keeps the full 17-bit subtrahend and computes a half-borrow from the low 12 bits.

Top module: `pair_alu16`

## Requirements
- R1: After reset, `pair_q`, `flags_q`, `done`, `busy` and `mem_rd` are all zero.
- R2: Flag layout is S=bit7, Z=bit6, H=bit4, X=bit3, V=bit2, N=bit1, C=bit0, and bit5 is never changed by an operation. While idle, `pair_ld` loads `pair_wdata` and `flag_ld` loads `flag_wdata`. Both loads are ignored while `busy` is high.
- R3: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 none. A `start` seen at an idle rising edge makes `busy` high. With `use_mem`=0, the result and `done` appear after the second rising edge. `done` lasts one cycle and `busy` falls with it. A `start` while busy is ignored.
- R4: With `use_mem`=1, `mem_rd` is high for two cycles. The first read is at `addr` and the second at `addr`+1 modulo 2^16. Read data returns the cycle after the request. The operand is {second byte, first byte}, and the result appears after the fourth rising edge.
- R5: Add: result = pair + operand. S is bit 15 and Z marks a zero result. C and X equal the carry out of bit 15, V is the carry into bit 15 XOR the carry out, N=0, and H is unchanged.
- R6: Add-with-carry: the operand becomes (operand + C) mod 2^16, then the R5 rules apply. An operand of 0xFFFF with C=1 leaves the pair unchanged and clears C.
- R7: Subtract: result = pair − operand mod 2^16, with N=1. C = (pair < operand unsigned). X is set when C is set and is otherwise unchanged. V marks a signed difference outside −32768..32767. S and Z follow the result, and H is unchanged.
- R8: Subtract-with-borrow: the subtrahend is operand + C, with no truncation. C = (pair < subtrahend) and N=1. H is set when pair[11:0] < subtrahend[11:0] and is otherwise unchanged. X is unchanged. V marks a signed pair − operand − C outside range. S and Z follow the result.
- R9: AND sets H=1, while XOR and OR clear H. All three clear X, N and C, set S from bit 15 and Z on zero, and leave V unchanged.
- R10: Code 7 leaves pair and flags unchanged but still pulses `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation when idle |
| op | input | 3 | Operation code |
| use_mem | input | 1 | 1: fetch operand from memory |
| opnd | input | 16 | Direct operand |
| addr | input | 16 | Memory operand address (low byte) |
| pair_ld | input | 1 | Load pair register when idle |
| pair_wdata | input | 16 | Pair load value |
| flag_ld | input | 1 | Load flag byte when idle |
| flag_wdata | input | 8 | Flag load value |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| pair_q | output | 16 | Pair register |
| flags_q | output | 8 | Flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Additions are tried with operands that give a plain sum, a carry out with signed overflow, a signed overflow without carry, and zero. This separates the C, V and Z paths and shows that H is kept. Add-with-carry uses an all-ones operand with the carry set, which tells the truncating fold apart from a 17-bit add. Subtractions cover a borrow, a signed overflow, an equal-operand zero and a no-borrow case with X preloaded, to show X is sticky. Subtract-with-borrow uses an all-ones operand with carry and a low-12-bit half-borrow. Logic operations run with V preloaded. Memory fetches include the top address, to exercise address wrap, alongside start and load pulses issued while busy.

// File: rtl/pair_alu16.sv
module pair_alu16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic        use_mem,
  input  logic [15:0] opnd,
  input  logic [15:0] addr,
  input  logic        pair_ld,
  input  logic [15:0] pair_wdata,
  input  logic        flag_ld,
  input  logic [7:0]  flag_wdata,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pair_q,
  output logic [7:0]  flags_q,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {IDLE, RDLO, RDHI, EXEC} st_t;
  st_t st;
  logic [2:0]  op_q;
  logic        mem_q;
  logic [15:0] opnd_q, addr_q;
  logic [7:0]  lo_q;

  assign busy     = (st != IDLE);
  assign mem_rd   = (st == RDLO) || (st == RDHI);
  assign mem_addr = (st == RDHI) ? addr_q + 16'd1 : addr_q;

  logic [15:0] b, badd, res;
  logic        cin, c15, ovf, is_sbc;
  logic [16:0] sum, sub2, diff, sdiff;
  logic [7:0]  f;

  assign cin    = flags_q[0];
  assign is_sbc = (op_q == 3'd3);
  assign b      = mem_q ? {mem_rdata, lo_q} : opnd_q;
  assign badd   = (op_q == 3'd1) ? b + {15'd0, cin} : b;
  assign sum    = {1'b0, pair_q} + {1'b0, badd};
  assign c15    = pair_q[15] ^ badd[15] ^ sum[15];
  assign sub2   = {1'b0, b} + {16'd0, is_sbc & cin};
  assign diff   = {1'b0, pair_q} - sub2;
  assign sdiff  = {pair_q[15], pair_q} - {b[15], b} - {16'd0, is_sbc & cin};
  assign ovf    = sdiff[16] ^ sdiff[15];

  always_comb begin
    f   = flags_q;
    res = pair_q;
    case (op_q)
      3'd0, 3'd1: begin
        res  = sum[15:0];
        f[3] = sum[16];
        f[2] = c15 ^ sum[16];
        f[1] = 1'b0;
        f[0] = sum[16];
      end
      3'd2, 3'd3: begin
        res  = diff[15:0];
        f[2] = ovf;
        f[1] = 1'b1;
        f[0] = diff[16];
        if (!is_sbc && diff[16]) f[3] = 1'b1;
        if (is_sbc && (pair_q[11:0] < sub2[11:0])) f[4] = 1'b1;
      end
      3'd4, 3'd5, 3'd6: begin
        res  = (op_q == 3'd4) ? (pair_q & b) : (op_q == 3'd5) ? (pair_q ^ b) : (pair_q | b);
        f[4] = (op_q == 3'd4);
        f[3] = 1'b0;
        f[1] = 1'b0;
        f[0] = 1'b0;
      end
      default: ;
    endcase
    if (op_q != 3'd7) begin
      f[7] = res[15];
      f[6] = (res == 16'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; op_q <= '0; mem_q <= 1'b0; opnd_q <= '0; addr_q <= '0;
      lo_q <= '0; pair_q <= '0; flags_q <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: begin
          if (pair_ld) pair_q <= pair_wdata;
          if (flag_ld) flags_q <= flag_wdata;
          if (start) begin
            op_q <= op; mem_q <= use_mem; opnd_q <= opnd; addr_q <= addr;
            st <= use_mem ? RDLO : EXEC;
          end
        end
        RDLO: st <= RDHI;
        RDHI: begin lo_q <= mem_rdata; st <= EXEC; end
        EXEC: begin
          pair_q <= res; flags_q <= f; done <= 1'b1; st <= IDLE;
        end
      endcase
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> mem_addr == $past(mem_addr) + 16'd1);
  assert_sub_n_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == 3'd2 || op_q == 3'd3)) |-> flags_q[1]);
  assert_logic_h_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q >= 3'd4 && op_q <= 3'd6) |-> (flags_q[4] == (op_q == 3'd4)) && !flags_q[0]);
  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q != 3'd7) |-> flags_q[6] == (pair_q == 16'd0));
  assert_pair_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pair_q) |-> (done || $past(pair_ld && !busy)));
endmodule

// File: tb/pair_alu16_bench.sv
module pair_alu16_bench;
  logic clk = 0, rst_n = 0;
  logic start = 0, use_mem = 0, pair_ld = 0, flag_ld = 0;
  logic [2:0] op = 0;
  logic [15:0] opnd = 0, addr = 0, pair_wdata = 0;
  logic [7:0] flag_wdata = 0, mem_rdata = 0;
  logic mem_rd, busy, done;
  logic [15:0] mem_addr, pair_q;
  logic [7:0] flags_q;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pair_alu16 u_pair_alu16 (.clk, .rst_n, .start, .op, .use_mem, .opnd, .addr,
    .pair_ld, .pair_wdata, .flag_ld, .flag_wdata, .mem_rd, .mem_addr, .mem_rdata,
    .pair_q, .flags_q, .busy, .done);

  function automatic int mem_fn(int a);
    return (a * 37 + (a / 256) * 11 + 90) % 256;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= 8'(mem_fn(int'(mem_addr)));

  int e_pair = 0, e_flags = 0, ph = 0, m_op, m_b, m_a, m_lo;
  bit e_done = 0, e_busy = 0, e_rd = 0, m_mem;
  int e_addr = 0;
  string tag = "R1";

  function automatic int setb(int v, int pos, bit x);
    return x ? (v | (1 << pos)) : (v & ~(1 << pos));
  endfunction

  task automatic model_exec();
    int a, b, c, f, res, bb, r, op2, sa, sb, cc, sres;
    bit c16, c15;
    a = e_pair; b = m_b; c = e_flags & 1; f = e_flags; res = a;
    if (m_op <= 1) begin
      bb = (m_op == 1) ? (b + c) % 65536 : b;
      r = a + bb; c16 = r > 65535;
      c15 = ((a % 32768) + (bb % 32768)) > 32767;
      res = r % 65536;
      f = setb(f, 3, c16); f = setb(f, 0, c16); f = setb(f, 1, 0); f = setb(f, 2, c15 ^ c16);
      tag = (m_op == 1) ? "R6" : "R5";
    end else if (m_op <= 3) begin
      cc = (m_op == 3) ? c : 0;
      op2 = b + cc;
      sa = (a >= 32768) ? a - 65536 : a;
      sb = (b >= 32768) ? b - 65536 : b;
      sres = sa - sb - cc;
      res = (a - op2 + 131072) % 65536;
      f = setb(f, 2, (sres < -32768) || (sres > 32767));
      f = setb(f, 0, a < op2); f = setb(f, 1, 1);
      if (m_op == 2 && a < op2) f = setb(f, 3, 1);
      if (m_op == 3 && (a % 4096) < (op2 % 4096)) f = setb(f, 4, 1);
      tag = (m_op == 3) ? "R8" : "R7";
    end else if (m_op <= 6) begin
      res = (m_op == 4) ? (a & b) : (m_op == 5) ? (a ^ b) : (a | b);
      f = setb(f, 4, m_op == 4); f = setb(f, 3, 0); f = setb(f, 1, 0); f = setb(f, 0, 0);
      tag = "R9";
    end else tag = "R10";
    if (m_op != 7) begin
      f = setb(f, 7, res >= 32768); f = setb(f, 6, res == 0);
    end
    e_pair = res; e_flags = f;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      e_pair = 0; e_flags = 0; ph = 0; e_done = 0; e_busy = 0; e_rd = 0;
    end else begin
      e_done = 0;
      case (ph)
        0: begin
          if (pair_ld) begin e_pair = pair_wdata; tag = "R2"; end
          if (flag_ld) begin e_flags = flag_wdata; tag = "R2"; end
          if (start) begin
            m_op = op; m_mem = use_mem; m_b = opnd; m_a = addr;
            ph = use_mem ? 1 : 3;
          end
        end
        1: ph = 2;
        2: begin m_lo = mem_fn(m_a); ph = 3; end
        default: begin
          if (m_mem) m_b = m_lo + 256 * mem_fn((m_a + 1) % 65536);
          model_exec(); e_done = 1; ph = 0;
        end
      endcase
      e_busy = ph != 0; e_rd = (ph == 1) || (ph == 2);
      e_addr = (ph == 1) ? m_a : (m_a + 1) % 65536;
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", t, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(tag, "pair", int'(pair_q), e_pair);
      chk(tag, "flags", int'(flags_q), e_flags);
      chk("R3", "done", int'(done), int'(e_done));
      chk("R3", "busy", int'(busy), int'(e_busy));
      chk("R4", "mem_rd", int'(mem_rd), int'(e_rd));
      if (e_rd) chk("R4", "mem_addr", int'(mem_addr), e_addr);
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic load(int p, int f);
    @(negedge clk);
    pair_ld = 1; pair_wdata = 16'(p); flag_ld = 1; flag_wdata = 8'(f);
    @(negedge clk);
    pair_ld = 0; flag_ld = 0;
  endtask

  task automatic go(int o, bit m, int b, int a);
    @(negedge clk);
    start = 1; op = 3'(o); use_mem = m; opnd = 16'(b); addr = 16'(a);
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);                          // R1 reset state compared here
    load(16'h1234, 8'h00);                   // R2
    go(0, 0, 16'h4321, 0);                   // R5 plain add
    load(16'h8000, 8'h10); go(0, 0, 16'h8000, 0);   // R5 carry, overflow, zero, H kept
    load(16'h7FFF, 8'h00); go(0, 0, 16'h0001, 0);   // R5 overflow no carry
    load(16'h2222, 8'h01); go(1, 0, 16'hFFFF, 0);   // R6 truncated fold
    load(16'h0100, 8'h01); go(1, 1, 0, 16'h0040);   // R6 memory operand, R4
    load(16'h0001, 8'h00); go(2, 0, 16'h0002, 0);   // R7 borrow
    load(16'h8000, 8'h00); go(2, 0, 16'h0001, 0);   // R7 overflow
    load(16'h5555, 8'h08); go(2, 0, 16'h5555, 0);   // R7 zero, X sticky
    load(16'h1234, 8'h01); go(3, 0, 16'hFFFF, 0);   // R8 full subtrahend
    load(16'h1000, 8'h00); go(3, 0, 16'h0001, 0);   // R8 half borrow
    load(16'hF0F0, 8'h04); go(4, 0, 16'h0FF0, 0);   // R9 AND, V kept
    load(16'hF0F0, 8'h14); go(5, 0, 16'hF0F0, 0);   // R9 XOR zero
    load(16'h0000, 8'h1D); go(6, 1, 0, 16'hFFFF);   // R9 OR, R4 address wrap
    load(16'hABCD, 8'hFF); go(7, 0, 16'h1111, 0);   // R10
    load(16'h0F00, 8'h20);                          // R2 bit5 untouched by ops
    @(negedge clk);
    start = 1; op = 3'd2; use_mem = 1; addr = 16'h1200;
    @(negedge clk);
    start = 0; pair_ld = 1; pair_wdata = 16'hDEAD; flag_ld = 1; flag_wdata = 8'hFF;
    @(negedge clk);
    start = 1; op = 3'd4;                           // R3 start while busy ignored
    @(negedge clk);
    start = 0; pair_ld = 0; flag_ld = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule